// File: doc/BRIEF.md
# Exception and Trap Entry Sequencer

This block sits beside the fetch stage of a small 32-bit processor core and decides where fetch goes when the core raises an exception, takes a software trap or returns from a handler. Three kinds of entry can be requested:

- an address fault;
- an unrecognised opcode;
- a numbered software trap, with a 4-bit number.

The core also presents the address of the current instruction and its status word. The block records that address in a saved-PC register. It keeps a one-deep chain behind it, so that a fault inside a handler does not lose the outer return point. It also keeps a saved copy of the status word.

One cycle after a request, the block pulses a redirect strobe. With the strobe it gives the fetch address and the status word that the core must load.

Handler entry points are offsets from a programmable vector base register. The core writes that register through a simple write strobe. A return request computes the resume point from the saved PC. It also unwinds the chain and hands back the saved status.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, the saved PC, chained PC, saved status and vector base all read 0, and no redirect is issued.
- R2: An address-fault request has three effects at the next clock edge. The chained PC takes the old saved PC. The saved status takes the whole current status. The saved PC takes the current instruction address. On that edge the block also redirects to vector base + 0x20.
- R3: On address-fault and trap entry, the status word handed to the core equals the current status AND 0x80. Bit 7 is the stack-mode bit, and it is the only bit kept.
- R4: A trap with number n redirects to vector base + 0x40 + 4*n, for every n from 0 to 15.
- R5: Trap entry saves state the same way as an address fault: it chains the saved PC, saves the whole status and saves the current address.
- R6: An unrecognised-opcode request has the following effects.
  - Status bits 7 (stack mode), 6 (interrupt enable) and 0 (condition) are copied into the same bits of the saved status. The other saved-status bits keep their values.
  - The status handed to the core is the current status with bits 6 and 0 cleared and every other bit kept.
  - The saved PC takes the current address, and the chained PC is unchanged.
  - Fetch is redirected to vector base + 0x10.
- R7: A return request has the following effects.
  - Fetch is redirected to (saved PC with bits 1:0 cleared) + 4.
  - The saved status is handed back as the new status.
  - The saved PC is reloaded from the chained PC.
  - The chained PC and the saved status are unchanged.
- R8: When several requests are raised together, only one is served. The order is address fault first, then unrecognised opcode, then trap, then return. One redirect is issued, and the lower-priority requests have no effect on any register.
- R9: A vector-base write takes effect at the next clock edge. An entry requested in the same cycle as the write uses the old base.
- R10: In a cycle with no request, no redirect is issued and the saved registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrFaultReq | input | 1 | Address fault on the current instruction |
| badOpReq | input | 1 | Unrecognised opcode on the current instruction |
| trapReq | input | 1 | Software trap request |
| trapNum | input | 4 | Trap number |
| retReq | input | 1 | Return-from-handler request |
| curPc | input | 32 | Address of the current instruction |
| curSts | input | 8 | Current status word |
| vecBaseWe | input | 1 | Vector base write strobe |
| vecBaseWdata | input | 32 | Vector base write data |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirectAddr | output | 32 | Redirected fetch address, valid with redirect |
| newSts | output | 8 | Status word to load, valid with redirect |
| savedPc | output | 32 | Saved PC register |
| chainPc | output | 32 | Chained (second-level) saved PC |
| savedSts | output | 8 | Saved status register |
| vecBase | output | 32 | Vector base register |

## Verification
The bench targets the following faults and what each would look like:

- **Saved-PC chain:** two nested faults followed by two returns. A design that overwrote the saved PC before chaining it would resume both returns at the inner address.
- **Status handling:** a sweep of all 256 status values through both fault kinds. Masking the wrong bit would show up as a lost or leaked stack-mode, interrupt-enable or condition bit. Saving the whole status word on an unrecognised opcode would show up as corrupted unrelated saved bits.
- **Trap vectors:** all sixteen trap numbers under several vector bases. This catches a missing shift or a wrong offset.
- **Request combinations:** every combination of the four requests. This catches a wrong priority order and a low-priority request that still changes a register.
- **Return alignment:** return addresses with non-zero low bits. These expose a resume point that was not aligned before the 4 was added.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  // Which request the control path has granted this cycle
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_FAULT,
    SRC_BADOP,
    SRC_TRAP,
    SRC_RET
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    fire;          // issue a redirect next edge
    logic    saveChain;     // chained PC <= saved PC
    logic    saveFullSts;   // saved status <= whole current status
    logic    saveOpBits;    // saved status <= selected current bits only
    logic    pcFromCur;     // saved PC <= current instruction address
    logic    pcFromChain;   // saved PC <= chained PC
    logic    baseWr;        // vector base <= write data
    srcSel_e src;
  } dpCtrl_t;

endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    addrFaultReq,
  input  logic    badOpReq,
  input  logic    trapReq,
  input  logic    retReq,
  input  logic    vecBaseWe,
  output dpCtrl_t ctrl
);

  localparam int NUM_SRC = 4;

  logic [NUM_SRC-1:0] reqVec;
  logic [NUM_SRC-1:0] grantVec;

  // Index 0 has the highest priority
  assign reqVec = {retReq, trapReq, badOpReq, addrFaultReq};

  // Fixed-priority grant: lowest index wins
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_grant
      if (i == 0) begin : g_first
        assign grantVec[i] = reqVec[i];
      end else begin : g_rest
        assign grantVec[i] = reqVec[i] & ~(|reqVec[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    ctrl = '0;
    ctrl.src    = SRC_NONE;
    ctrl.baseWr = vecBaseWe;
    ctrl.fire   = |grantVec;
    unique case (1'b1)
      grantVec[0]: begin
        ctrl.src         = SRC_FAULT;
        ctrl.saveChain   = 1'b1;
        ctrl.saveFullSts = 1'b1;
        ctrl.pcFromCur   = 1'b1;
      end
      grantVec[1]: begin
        ctrl.src        = SRC_BADOP;
        ctrl.saveOpBits = 1'b1;
        ctrl.pcFromCur  = 1'b1;
      end
      grantVec[2]: begin
        ctrl.src         = SRC_TRAP;
        ctrl.saveChain   = 1'b1;
        ctrl.saveFullSts = 1'b1;
        ctrl.pcFromCur   = 1'b1;
      end
      grantVec[3]: begin
        ctrl.src         = SRC_RET;
        ctrl.pcFromChain = 1'b1;
      end
      default: ;
    endcase
  end

  // R8: at most one request granted per cycle
  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  // R8: an address fault always wins
  p_fault_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrFaultReq |-> (ctrl.src == SRC_FAULT));

  // R8: the two saved-PC load sources are never taken together
  p_pc_src_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.pcFromCur && ctrl.pcFromChain));

endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          STS_W     = 8,
  parameter int          TNUM_W    = 4,
  parameter int          SM_BIT    = 7,
  parameter int          IE_BIT    = 6,
  parameter int          CC_BIT    = 0,
  parameter int unsigned BADOP_OFF = 'h10,
  parameter int unsigned FAULT_OFF = 'h20,
  parameter int unsigned TRAP_OFF  = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [TNUM_W-1:0] trapNum,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [STS_W-1:0]  curSts,
  input  logic [ADDR_W-1:0] vecBaseWdata,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic [STS_W-1:0]  newSts,
  output logic [ADDR_W-1:0] savedPc,
  output logic [ADDR_W-1:0] chainPc,
  output logic [STS_W-1:0]  savedSts,
  output logic [ADDR_W-1:0] vecBase
);

  localparam logic [STS_W-1:0] ONE_STS  = {{(STS_W-1){1'b0}}, 1'b1};
  localparam logic [STS_W-1:0] SM_MASK  = ONE_STS << SM_BIT;
  localparam logic [STS_W-1:0] IE_MASK  = ONE_STS << IE_BIT;
  localparam logic [STS_W-1:0] CC_MASK  = ONE_STS << CC_BIT;
  localparam logic [STS_W-1:0] OP_MASK  = SM_MASK | IE_MASK | CC_MASK;
  localparam logic [STS_W-1:0] OP_CLR   = IE_MASK | CC_MASK;
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(4);

  logic              redirectQ;
  logic [ADDR_W-1:0] redirAddrQ;
  logic [STS_W-1:0]  newStsQ;
  logic [ADDR_W-1:0] bpcQ;
  logic [ADDR_W-1:0] bbpcQ;
  logic [STS_W-1:0]  bstsQ;
  logic [ADDR_W-1:0] baseQ;

  logic [ADDR_W-1:0] trapOfs;
  logic [ADDR_W-1:0] resumeAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [STS_W-1:0]  nextSts;

  assign trapOfs    = ADDR_W'({trapNum, 2'b00});
  assign resumeAddr = {bpcQ[ADDR_W-1:2], 2'b00} + STEP;

  // Target address and status for the granted source
  always_comb begin
    nextAddr = '0;
    nextSts  = '0;
    unique case (ctrl.src)
      SRC_FAULT: begin
        nextAddr = baseQ + ADDR_W'(FAULT_OFF);
        nextSts  = curSts & SM_MASK;
      end
      SRC_BADOP: begin
        nextAddr = baseQ + ADDR_W'(BADOP_OFF);
        nextSts  = curSts & ~OP_CLR;
      end
      SRC_TRAP: begin
        nextAddr = baseQ + ADDR_W'(TRAP_OFF) + trapOfs;
        nextSts  = curSts & SM_MASK;
      end
      SRC_RET: begin
        nextAddr = resumeAddr;
        nextSts  = bstsQ;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectQ  <= 1'b0;
      redirAddrQ <= '0;
      newStsQ    <= '0;
      bpcQ       <= '0;
      bbpcQ      <= '0;
      bstsQ      <= '0;
      baseQ      <= '0;
    end else begin
      redirectQ <= ctrl.fire;
      if (ctrl.fire) begin
        redirAddrQ <= nextAddr;
        newStsQ    <= nextSts;
      end
      if (ctrl.saveChain)   bbpcQ <= bpcQ;
      if (ctrl.saveFullSts) bstsQ <= curSts;
      else if (ctrl.saveOpBits)
        bstsQ <= (bstsQ & ~OP_MASK) | (curSts & OP_MASK);
      if (ctrl.pcFromCur)        bpcQ <= curPc;
      else if (ctrl.pcFromChain) bpcQ <= bbpcQ;
      if (ctrl.baseWr) baseQ <= vecBaseWdata;
    end
  end

  assign redirect     = redirectQ;
  assign redirectAddr = redirAddrQ;
  assign newSts       = newStsQ;
  assign savedPc      = bpcQ;
  assign chainPc      = bbpcQ;
  assign savedSts     = bstsQ;
  assign vecBase      = baseQ;

  // R2: the chain receives the previous saved PC
  p_chain_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.saveChain |=> (bbpcQ == $past(bpcQ)));

  // R3: fault and trap entry keep only stack mode
  p_sm_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.src == SRC_FAULT || ctrl.src == SRC_TRAP) |=>
      ((newStsQ & ~SM_MASK) == '0) && (newStsQ[SM_BIT] == $past(curSts[SM_BIT])));

  // R6: bad opcode clears interrupt enable and condition, keeps stack mode
  p_badop_sts_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.src == SRC_BADOP) |=>
      !newStsQ[IE_BIT] && !newStsQ[CC_BIT] && (newStsQ[SM_BIT] == $past(curSts[SM_BIT])));

  // R6: bad opcode leaves the chain alone
  p_badop_chain_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.src == SRC_BADOP) |=> $stable(bbpcQ));

  // R7: return unwinds the chain and restores status
  p_ret_unwind_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.src == SRC_RET) |=>
      (bpcQ == $past(bbpcQ)) && (newStsQ == $past(bstsQ)) && redirAddrQ[1:0] == 2'b00);

  // R10: nothing moves without a request
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.fire |=> !redirectQ && $stable(bpcQ) && $stable(bbpcQ) && $stable(bstsQ));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrFaultReq,
  input  logic        badOpReq,
  input  logic        trapReq,
  input  logic [3:0]  trapNum,
  input  logic        retReq,
  input  logic [31:0] curPc,
  input  logic [7:0]  curSts,
  input  logic        vecBaseWe,
  input  logic [31:0] vecBaseWdata,
  output logic        redirect,
  output logic [31:0] redirectAddr,
  output logic [7:0]  newSts,
  output logic [31:0] savedPc,
  output logic [31:0] chainPc,
  output logic [7:0]  savedSts,
  output logic [31:0] vecBase
);

  dpCtrl_t ctrl;

  trap_entry_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .addrFaultReq (addrFaultReq),
    .badOpReq     (badOpReq),
    .trapReq      (trapReq),
    .retReq       (retReq),
    .vecBaseWe    (vecBaseWe),
    .ctrl         (ctrl)
  );

  trap_entry_dp #(
    .ADDR_W (32),
    .STS_W  (8),
    .TNUM_W (4)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .trapNum      (trapNum),
    .curPc        (curPc),
    .curSts       (curSts),
    .vecBaseWdata (vecBaseWdata),
    .redirect     (redirect),
    .redirectAddr (redirectAddr),
    .newSts       (newSts),
    .savedPc      (savedPc),
    .chainPc      (chainPc),
    .savedSts     (savedSts),
    .vecBase      (vecBase)
  );

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        addrFaultReq, badOpReq, trapReq, retReq, vecBaseWe;
  logic [3:0]  trapNum;
  logic [31:0] curPc, vecBaseWdata;
  logic [7:0]  curSts;
  logic        redirect;
  logic [31:0] redirectAddr, savedPc, chainPc, vecBase;
  logic [7:0]  newSts, savedSts;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference model state
  logic [31:0] mBpc, mBbpc, mBase;
  logic [7:0]  mBsts;

  always #2.5 clk = ~clk;

  trap_entry_unit u_dut (
    .clk(clk), .rstN(rstN), .addrFaultReq(addrFaultReq), .badOpReq(badOpReq),
    .trapReq(trapReq), .trapNum(trapNum), .retReq(retReq), .curPc(curPc),
    .curSts(curSts), .vecBaseWe(vecBaseWe), .vecBaseWdata(vecBaseWdata),
    .redirect(redirect), .redirectAddr(redirectAddr), .newSts(newSts),
    .savedPc(savedPc), .chainPc(chainPc), .savedSts(savedSts), .vecBase(vecBase)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; model computes expectation; outputs checked after edge
  task automatic step(input string req, input bit a, input bit b, input bit t,
                      input logic [3:0] n, input bit r, input logic [31:0] pc,
                      input logic [7:0] sts, input bit we, input logic [31:0] wd);
    bit          fire;
    logic [31:0] eAddr;
    logic [7:0]  eSts;
    @(negedge clk);
    addrFaultReq = a; badOpReq = b; trapReq = t; trapNum = n; retReq = r;
    curPc = pc; curSts = sts; vecBaseWe = we; vecBaseWdata = wd;
    fire = 1'b1; eAddr = '0; eSts = '0;
    if (a) begin
      eAddr = mBase + 32'h20; eSts = sts & 8'h80;
      mBbpc = mBpc; mBsts = sts; mBpc = pc;
    end else if (b) begin
      eAddr = mBase + 32'h10; eSts = sts & 8'hBE;
      mBsts = (mBsts & 8'h3E) | (sts & 8'hC1); mBpc = pc;
    end else if (t) begin
      eAddr = mBase + 32'h40 + 32'(n) * 4; eSts = sts & 8'h80;
      mBbpc = mBpc; mBsts = sts; mBpc = pc;
    end else if (r) begin
      eAddr = (mBpc & ~32'h3) + 32'h4; eSts = mBsts;
      mBpc = mBbpc;
    end else fire = 1'b0;
    if (we) mBase = wd;
    @(posedge clk); #1;
    chk(req, "redirect", 32'(redirect), 32'(fire));
    if (fire) begin
      chk(req, "redirectAddr", redirectAddr, eAddr);
      chk(req, "newSts", 32'(newSts), 32'(eSts));
    end
    chk(req, "savedPc", savedPc, mBpc);
    chk(req, "chainPc", chainPc, mBbpc);
    chk(req, "savedSts", 32'(savedSts), 32'(mBsts));
    chk(req, "vecBase", vecBase, mBase);
    addrFaultReq = 0; badOpReq = 0; trapReq = 0; retReq = 0; vecBaseWe = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; addrFaultReq = 0; badOpReq = 0; trapReq = 0; retReq = 0;
    vecBaseWe = 0; trapNum = 0; curPc = 0; curSts = 0; vecBaseWdata = 0;
    mBpc = 0; mBbpc = 0; mBase = 0; mBsts = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "redirect", 32'(redirect), 0);
    chk("R1", "savedPc", savedPc, 0);
    chk("R1", "chainPc", chainPc, 0);
    chk("R1", "savedSts", 32'(savedSts), 0);
    chk("R1", "vecBase", vecBase, 0);
    @(negedge clk); rstN = 1;

    // R10: idle cycles
    for (int i = 0; i < 3; i++) step("R10", 0,0,0,0,0, 32'h1234_5678, 8'hFF, 0, 0);

    // R9: base write, with an entry in the same cycle using the old base
    step("R9", 1,0,0,0,0, 32'h0000_1000, 8'hA5, 1, 32'h8000_0000);
    step("R9", 0,0,1,4'd3,0, 32'h0000_1004, 8'h81, 0, 0);

    // R2/R3/R7: nested faults then two returns, unaligned PCs
    step("R2", 1,0,0,0,0, 32'h0000_2002, 8'h3C, 0, 0);
    step("R2", 1,0,0,0,0, 32'h0000_3001, 8'hC3, 0, 0);
    step("R7", 0,0,0,0,1, 32'h0, 8'h00, 0, 0);
    step("R7", 0,0,0,0,1, 32'h0, 8'h00, 0, 0);

    // R3/R2: address fault over every status value
    for (int s = 0; s < 256; s++)
      step("R3", 1,0,0,0,0, 32'h4000_0000 + 32'(s), 8'(s), 0, 0);
    // R6: bad opcode over every status value (first preset saved status)
    step("R6", 1,0,0,0,0, 32'h10, 8'h5A, 0, 0);
    for (int s = 0; s < 256; s++)
      step("R6", 0,1,0,0,0, 32'h5000_0000 + 32'(s*4), 8'(s), 0, 0);

    // R4/R5: every trap number under several bases
    for (int b = 0; b < 3; b++) begin
      step("R9", 0,0,0,0,0, 0, 0, 1, 32'h0001_0000 * 32'(b) + 32'(b*8));
      for (int n = 0; n < 16; n++)
        step("R4", 0,0,1,4'(n),0, 32'h6000_0000 + 32'(n*2), 8'(n*17), 0, 0);
      step("R5", 0,0,0,0,1, 0, 0, 0, 0);
    end

    // R8: every combination of requests
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 2; k++)
        step("R8", c[0], c[1], c[2], 4'(c+k), c[3],
             32'h7000_0000 + 32'(c*16+k*3), 8'(c*37+k), 0, 0);

    // R10: idle hold after activity
    step("R10", 0,0,0,4'd9,0, 32'hDEAD_BEEF, 8'hFF, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule